// File: doc/BRIEF.md
# Two-Phase Shake Event Detector

This block decides whether a device has been shaken. On each valid sample strobe it looks at the acceleration component that lies across the current long-term orientation. A shake is a first swing past a programmable threshold, followed within a programmable number of readings by a swing the other way. When a shake is found, the block raises a one-cycle pulse and updates a 2-bit direction code that reflects the sign of the first swing.

The surrounding logic supplies the orientation code and the two signed 8-bit axis readings (64 LSB per g). It also supplies three configuration fields: threshold select, window select and mode. The interrupt-pending flag feeds back as a lock input. While that flag is high, no new shake is armed or recorded and the last direction code is held. When the flag drops, the code is cleared.

Top module: `shake_detector`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `shake_pulse` is 0, `shake_code` is 00 and the detector is idle, with nothing armed.
- R2: The examined value is `ax` when `orient` is 01 or 11 (`orient[0]`=1). It is `ay` when `orient` is 00 or 10. The other axis has no effect.
- R3: `thr_sel` 00/01/10/11 selects thresholds of 32/64/96/127 LSB. An idle detector arms on a sample where the value is strictly above +threshold, remembering positive, or strictly below −threshold, remembering negative. At 11, only −128 can arm, and only on the negative side.
- R4: With `mode`=0, an armed detector reports only on a sample that crosses the same threshold strictly, on the side opposite to the first swing.
- R5: With `mode`=1, an armed detector reports on any sample whose sign is strictly opposite to the first swing. Zero does not count as a reversal.
- R6: `win_sel` 00/01/10/11 gives a window of N = 16/32/64/128 readings. The second swing is accepted on readings 1 to N after the arming reading. Cycles without `smp_vld` do not count. If reading N does not qualify, the detector returns to idle, and a later reading can arm it again.
- R7: A report drives `shake_pulse` high for exactly one cycle, on the cycle after the qualifying strobe edge. In that same cycle `shake_code` becomes 01 (first swing positive) or 10 (first swing negative). Code 11 never appears.
- R8: At any clock edge with `lock` high, any armed state is dropped, nothing arms, no pulse is issued and `shake_code` is held.
- R9: `shake_code` changes only on a report, or at the first edge where `lock` is low after having been high at the previous edge. At that edge it is cleared to 00.
- R10: While armed, a further swing with the same sign as the first neither reports nor restarts the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One reading is present on this cycle |
| ax | input | 8 | Signed X reading, 64 LSB/g |
| ay | input | 8 | Signed Y reading, 64 LSB/g |
| orient | input | 2 | Long-term orientation code |
| thr_sel | input | 2 | Threshold select |
| win_sel | input | 2 | Window length select |
| mode | input | 1 | 0: opposite crossing needed, 1: sign reversal suffices |
| lock | input | 1 | Interrupt pending; blocks detection |
| shake_pulse | output | 1 | One-cycle shake report |
| shake_code | output | 2 | 00 none, 01 first swing positive, 10 first swing negative |

## Verification
The hardest situation to reach from the ports is the exact end of the window. This includes reading N qualifying, reading N+1 arriving just after expiry, and a run of same-sign swings that must not restart the count. The stimulus counts strobes precisely and mixes in idle cycles that must not advance the window. A qualifying sample just after expiry must then re-arm the detector in the opposite direction instead of reporting. The longest window and the saturated threshold at −128 are also driven.

// File: rtl/shk_pkg.sv
package shk_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } shk_state_e;

  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_POS  = 2'b01;
  localparam logic [1:0] CODE_NEG  = 2'b10;
endpackage

// File: rtl/shk_axis_cmp.sv
module shk_axis_cmp #(
  parameter int DATA_W    = 8,
  parameter int LSB_PER_G = 64
) (
  input  logic signed [DATA_W-1:0] ax_i,
  input  logic signed [DATA_W-1:0] ay_i,
  input  logic [1:0]               orient_i,
  input  logic [1:0]               thr_sel_i,
  output logic                     over_pos_o,
  output logic                     over_neg_o,
  output logic                     sgn_pos_o,
  output logic                     sgn_neg_o
);
  localparam int EXT_W   = DATA_W + 2;
  localparam int MAX_POS = (2 ** (DATA_W - 1)) - 1;

  logic signed [EXT_W-1:0] thr_tab [4];

  // threshold steps of half a g, clipped to the largest positive code
  for (genvar g = 0; g < 4; g++) begin : g_thr
    localparam int RAW  = ((g + 1) * LSB_PER_G) / 2;
    localparam int CLIP = (RAW > MAX_POS) ? MAX_POS : RAW;
    assign thr_tab[g] = EXT_W'(CLIP);
  end

  logic signed [DATA_W-1:0] perp;
  logic signed [EXT_W-1:0]  perp_x;
  logic signed [EXT_W-1:0]  thr;

  always_comb begin
    perp       = orient_i[0] ? ax_i : ay_i;
    perp_x     = {{2{perp[DATA_W-1]}}, perp};
    thr        = thr_tab[thr_sel_i];
    over_pos_o = perp_x > thr;
    over_neg_o = perp_x < -thr;
    sgn_pos_o  = perp_x > 0;
    sgn_neg_o  = perp[DATA_W-1];
  end
endmodule

// File: rtl/shk_window.sv
module shk_window #(
  parameter int WIN_BASE = 16,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [SEL_W-1:0] win_sel_i,
  output logic             last_o
);
  localparam int WIN_MAX = WIN_BASE << ((2 ** SEL_W) - 1);
  localparam int CNT_W   = $clog2(WIN_MAX) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit_m1;

  assign limit_m1 = CNT_W'((WIN_BASE << win_sel_i) - 1);
  assign last_o   = (cnt == limit_m1);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt <= '0;
    end else if (step_i) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/shk_ctrl.sv
module shk_ctrl
  import shk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       smp_vld_i,
  input  logic       lock_i,
  input  logic       mode_i,
  input  logic       over_pos_i,
  input  logic       over_neg_i,
  input  logic       sgn_pos_i,
  input  logic       sgn_neg_i,
  input  logic       win_last_i,
  output logic       win_clr_o,
  output logic       win_step_o,
  output logic       pulse_o,
  output logic [1:0] code_o
);
  shk_state_e state_q, state_n;
  logic       neg_q, neg_n;
  logic       lock_q;
  logic       report;
  logic       qual;

  always_comb begin
    state_n    = state_q;
    neg_n      = neg_q;
    win_clr_o  = 1'b0;
    win_step_o = 1'b0;
    report     = 1'b0;
    qual       = neg_q ? (mode_i ? sgn_pos_i : over_pos_i)
                       : (mode_i ? sgn_neg_i : over_neg_i);
    if (lock_i) begin
      state_n = ST_IDLE;
    end else if (smp_vld_i) begin
      case (state_q)
        ST_IDLE: begin
          if (over_pos_i) begin
            state_n   = ST_ARMED;
            neg_n     = 1'b0;
            win_clr_o = 1'b1;
          end else if (over_neg_i) begin
            state_n   = ST_ARMED;
            neg_n     = 1'b1;
            win_clr_o = 1'b1;
          end
        end
        ST_ARMED: begin
          if (qual) begin
            report  = 1'b1;
            state_n = ST_IDLE;
          end else if (win_last_i) begin
            state_n = ST_IDLE;
          end else begin
            win_step_o = 1'b1;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      neg_q   <= 1'b0;
      lock_q  <= 1'b0;
      pulse_o <= 1'b0;
      code_o  <= CODE_NONE;
    end else begin
      state_q <= state_n;
      neg_q   <= neg_n;
      lock_q  <= lock_i;
      pulse_o <= report;
      if (report) begin
        code_o <= neg_q ? CODE_NEG : CODE_POS;
      end else if (lock_q && !lock_i) begin
        code_o <= CODE_NONE;
      end
    end
  end
endmodule

// File: rtl/shake_detector.sv
module shake_detector #(
  parameter int DATA_W    = 8,
  parameter int LSB_PER_G = 64,
  parameter int WIN_BASE  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] ax,
  input  logic signed [DATA_W-1:0] ay,
  input  logic [1:0]               orient,
  input  logic [1:0]               thr_sel,
  input  logic [1:0]               win_sel,
  input  logic                     mode,
  input  logic                     lock,
  output logic                     shake_pulse,
  output logic [1:0]               shake_code
);
  logic over_pos, over_neg, sgn_pos, sgn_neg;
  logic win_clr, win_step, win_last;

  shk_axis_cmp #(
    .DATA_W    (DATA_W),
    .LSB_PER_G (LSB_PER_G)
  ) cmp_i (
    .ax_i       (ax),
    .ay_i       (ay),
    .orient_i   (orient),
    .thr_sel_i  (thr_sel),
    .over_pos_o (over_pos),
    .over_neg_o (over_neg),
    .sgn_pos_o  (sgn_pos),
    .sgn_neg_o  (sgn_neg)
  );

  shk_window #(
    .WIN_BASE (WIN_BASE),
    .SEL_W    (2)
  ) win_i (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (win_clr),
    .step_i    (win_step),
    .win_sel_i (win_sel),
    .last_o    (win_last)
  );

  shk_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .smp_vld_i  (smp_vld),
    .lock_i     (lock),
    .mode_i     (mode),
    .over_pos_i (over_pos),
    .over_neg_i (over_neg),
    .sgn_pos_i  (sgn_pos),
    .sgn_neg_i  (sgn_neg),
    .win_last_i (win_last),
    .win_clr_o  (win_clr),
    .win_step_o (win_step),
    .pulse_o    (shake_pulse),
    .code_o     (shake_code)
  );
endmodule

// File: rtl/shake_detector_chk.sv
module shake_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       smp_vld,
  input logic       lock,
  input logic       shake_pulse,
  input logic [1:0] shake_code
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!shake_pulse && shake_code == 2'b00)); // R1

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    shake_code != 2'b11); // R7

  AST_PULSE_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
    shake_pulse |-> shake_code != 2'b00); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    shake_pulse |=> !shake_pulse); // R7

  AST_PULSE_NEEDS_SMP: assert property (@(posedge clk) disable iff (rst)
    shake_pulse |-> $past(smp_vld)); // R6

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    shake_pulse |-> !$past(lock)); // R8

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!shake_pulse && !($past(lock, 2) && !$past(lock))) |-> $stable(shake_code)); // R9
endmodule

bind shake_detector shake_detector_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .smp_vld     (smp_vld),
  .lock        (lock),
  .shake_pulse (shake_pulse),
  .shake_code  (shake_code)
);

// File: tb/shake_detector_tb_top.sv
`timescale 1ns/1ps
module shake_detector_tb_top;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_vld = 1'b0;
  logic signed [7:0] ax = '0;
  logic signed [7:0] ay = '0;
  logic [1:0]        orient = 2'b00;
  logic [1:0]        thr_sel = 2'b00;
  logic [1:0]        win_sel = 2'b00;
  logic              mode = 1'b0;
  logic              lock = 1'b0;
  logic              shake_pulse;
  logic [1:0]        shake_code;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  shake_detector dut_i (
    .clk (clk), .rst (rst), .smp_vld (smp_vld), .ax (ax), .ay (ay),
    .orient (orient), .thr_sel (thr_sel), .win_sel (win_sel),
    .mode (mode), .lock (lock),
    .shake_pulse (shake_pulse), .shake_code (shake_code)
  );

  // behavioural reference
  bit m_armed, m_neg, m_pulse, m_lq;
  int m_k, m_code;

  always @(posedge clk) begin
    int perp, thr, win;
    bit qual, rep;
    if (rst) begin
      m_armed = 0; m_neg = 0; m_pulse = 0; m_lq = 0; m_k = 0; m_code = 0;
    end else begin
      perp = orient[0] ? int'(ax) : int'(ay);
      thr  = (thr_sel == 2'd3) ? 127 : (int'(thr_sel) + 1) * 32;
      win  = 16 << win_sel;
      rep  = 0;
      if (lock) m_armed = 0;
      else if (smp_vld) begin
        if (!m_armed) begin
          if (perp > thr) begin m_armed = 1; m_neg = 0; m_k = 0; end
          else if (perp < -thr) begin m_armed = 1; m_neg = 1; m_k = 0; end
        end else begin
          m_k++;
          qual = m_neg ? (mode ? perp > 0 : perp > thr) : (mode ? perp < 0 : perp < -thr);
          if (qual) begin rep = 1; m_code = m_neg ? 2 : 1; m_armed = 0; end
          else if (m_k >= win) m_armed = 0;
        end
      end
      if (!rep && m_lq && !lock) m_code = 0;
      m_lq = lock;
      m_pulse = rep;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(shake_pulse == m_pulse, "R7 model pulse", int'(shake_pulse), int'(m_pulse));
      chk(int'(shake_code) == m_code, "R7 model code", int'(shake_code), m_code);
    end
  end

  task automatic expect_out(input string tag, input bit p, input int c);
    chk(shake_pulse == p, tag, int'(shake_pulse), int'(p));
    chk(int'(shake_code) == c, tag, int'(shake_code), c);
  endtask

  task automatic smp(input int x, input int y);
    smp_vld = 1'b1; ax = 8'(x); ay = 8'(y);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic unlock_clear();
    lock = 1'b1; @(negedge clk);
    lock = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    expect_out("R1 reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);

    // R4: basic opposite crossing, first swing positive
    smp(0, 40); expect_out("R4 armed no pulse", 0, 0);
    smp(0, -40); expect_out("R4 report pos", 1, 1);
    @(negedge clk); expect_out("R7 pulse one cycle", 0, 1);
    unlock_clear(); expect_out("R9 cleared on lock fall", 0, 0);

    // R4: reversal below threshold does not report in mode 0
    smp(0, 40); smp(0, -10); expect_out("R4 weak reversal ignored", 0, 0);
    smp(0, -33); expect_out("R4 second crossing", 1, 1);
    unlock_clear();

    // R5: mode 1 sign reversal, zero is no reversal
    mode = 1'b1;
    smp(0, -40); smp(0, 0); expect_out("R5 zero not reversal", 0, 0);
    smp(0, 5); expect_out("R5 reversal reports neg", 1, 2);
    unlock_clear();
    mode = 1'b0;

    // R2: axis choice
    orient = 2'b00;
    smp(90, 0); smp(-90, 0); expect_out("R2 ax ignored when orient 00", 0, 0);
    orient = 2'b01;
    smp(50, 0); smp(-50, -50); expect_out("R2 ax used orient 01", 1, 1);
    unlock_clear();
    orient = 2'b11;
    smp(-50, 100); smp(50, -100); expect_out("R2 ax used orient 11", 1, 2);
    unlock_clear();
    orient = 2'b10;
    smp(100, -50); smp(-100, 50); expect_out("R2 ay used orient 10", 1, 2);
    unlock_clear();
    orient = 2'b00;

    // R3: threshold edges
    thr_sel = 2'd1;
    smp(0, 64); smp(0, -64); smp(0, 64); expect_out("R3 equal not crossing", 0, 0);
    smp(0, 65); smp(0, -65); expect_out("R3 65 over 64", 1, 1);
    unlock_clear();
    thr_sel = 2'd2;
    smp(0, 97); smp(0, -96); expect_out("R3 96 equal no report", 0, 0);
    smp(0, -97); expect_out("R3 97 crossing", 1, 1);
    unlock_clear();
    thr_sel = 2'd3;
    smp(0, 127); smp(0, -127); expect_out("R3 2g no arm", 0, 0);
    smp(0, -128); smp(0, 127); expect_out("R3 2g pos never crosses", 0, 0);
    unlock_clear();
    mode = 1'b1;
    smp(0, -128); smp(0, 127); expect_out("R3 saturated neg arm", 1, 2);
    unlock_clear();
    mode = 1'b0; thr_sel = 2'd0;

    // R6: reading N accepted
    smp(0, 40);
    for (int i = 0; i < 15; i++) smp(0, 0);
    smp(0, -40); expect_out("R6 reading 16 accepted", 1, 1);
    unlock_clear();
    // R6: expiry then re-arm
    smp(0, 40);
    for (int i = 0; i < 16; i++) smp(0, 0);
    smp(0, -40); expect_out("R6 after expiry re-arms", 0, 0);
    smp(0, 40); expect_out("R6 re-armed report", 1, 2);
    unlock_clear();
    // R6: idle cycles do not count
    smp(0, 40);
    repeat (40) @(negedge clk);
    smp(0, -40); expect_out("R6 idle cycles not counted", 1, 1);
    unlock_clear();
    // R6: longest window
    win_sel = 2'd3;
    smp(0, -40);
    for (int i = 0; i < 127; i++) smp(0, 0);
    smp(0, 40); expect_out("R6 reading 128 accepted", 1, 2);
    unlock_clear();
    win_sel = 2'd0;

    // R10: same-sign swings do not restart window
    smp(0, 40);
    for (int i = 0; i < 16; i++) smp(0, 50);
    smp(0, -40); expect_out("R10 no restart", 0, 0);
    smp(0, 40); expect_out("R10 re-arm neg", 1, 2);
    unlock_clear();

    // R8: lock blocks and holds code
    smp(0, 40); smp(0, -40); expect_out("R8 setup", 1, 1);
    lock = 1'b1;
    smp(0, -40); smp(0, 40); smp(0, -40); expect_out("R8 locked hold", 0, 1);
    lock = 1'b0; @(negedge clk); expect_out("R9 clear after unlock", 0, 0);
    smp(0, 40); lock = 1'b1; @(negedge clk); lock = 1'b0;
    smp(0, -40); expect_out("R8 armed state dropped", 0, 0);
    smp(0, 40); expect_out("R8 new arm after drop", 1, 2);
    repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule